// File: doc/BRIEF.md
# Range and Decade Divider Selector

This block divides a pulse stream, such as the output of a voltage-to-frequency stage, by a ratio chosen with two independent controls. A range control either sends the stream through a chain of three decade counters, which divides by one thousand for the low-frequency range, or lets it bypass that chain for the high-frequency range. After that, a two-bit decimal code passes the stream unchanged or sends it through one or two more decade counters.

Everything runs on one fast system clock. The block finds rising edges of the pulse input synchronously. Each rising edge is one input event. Each completed division makes one single-cycle output pulse. When either control changes, every counter clears, so the next output arrives only after a full ratio's worth of new input edges.

Top module: `range_decade_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` is low and every counter is cleared. After reset, the first output pulse appears only after a full ratio of input rising edges.
- R2: With `range_lo` = 0 and `dp_code` = 2'b00, every rising edge of `pulse_in` makes one output pulse.
- R3: `dp_code` values 2'b01 and 2'b10 both divide by 10.
- R4: `dp_code` = 2'b11 divides by 100, using two cascaded decade counters.
- R5: `range_lo` = 1 adds a divide by 1000 in series with the decimal division. The total ratio is 1000 times the decimal ratio. `range_lo` = 0 bypasses this divide.
- R6: `div_out` is high for exactly one clock. It rises two clock edges after the edge at which `pulse_in` is first sampled high, counted on the input edge that completes the ratio.
- R7: When `range_lo` or `dp_code` differs from its value at the previous clock edge, all counters clear and `div_out` is low in the following cycle.
- R8: A `pulse_in` held high for many cycles counts as a single input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Pulse stream to divide. High and low phases each last at least one clock |
| range_lo | input | 1 | 1: low range, divide by 1000. 0: high range, bypass |
| dp_code | input | 2 | Decimal division: 00 divide by 1, 01 or 10 divide by 10, 11 divide by 100 |
| div_out | output | 1 | Single-cycle pulse, one per completed division |

## Verification
The bench drives bursts at the fastest legal rate, with input high and low for one clock each. At that rate, a design that let one output pulse span two cycles, or that dropped back-to-back edges, gives a wrong count or a mistimed pulse against the reference model.

It drives both mid-range codes. A mapping that sent 2'b10 to divide by 100 shows up as missing pulses.

It drives the low range combined with a decimal divide. A design that ran the two paths in parallel instead of in series produces pulses too early.

It changes the controls after a partial burst. A design that kept the stale counts fires its first pulse too soon. A long-held input would count more than once if the design were level-sensitive.

// File: rtl/range_decade_divider.sv
module range_decade_divider #(
  parameter int RADIX      = 10,
  parameter int RANGE_STGS = 3,
  parameter int DEC_STGS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_in,
  input  logic       range_lo,
  input  logic [1:0] dp_code,
  output logic       div_out
);

  localparam int CNT_W = $clog2(RADIX);
  localparam int NSTG  = RANGE_STGS + DEC_STGS;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(RADIX - 1);

  logic            in_q, in_q2;
  logic [2:0]      cfg_q;
  logic            clr;
  logic            rise;
  logic            range_strobe;
  logic            out_strobe;
  logic [NSTG-1:0] stg_in;
  logic [NSTG-1:0] carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      in_q2 <= 1'b0;
      cfg_q <= {range_lo, dp_code};
    end else begin
      in_q  <= pulse_in;
      in_q2 <= in_q;
      cfg_q <= {range_lo, dp_code};
    end
  end

  assign clr  = (cfg_q != {range_lo, dp_code});
  assign rise = in_q & ~in_q2 & ~clr;

  genvar i;
  generate
    for (i = 0; i < NSTG; i++) begin : g_stg
      logic [CNT_W-1:0] cnt;

      if (i == 0) begin : g_first
        assign stg_in[i] = rise;
      end else if (i == RANGE_STGS) begin : g_dec_head
        assign stg_in[i] = range_strobe;
      end else begin : g_chain
        assign stg_in[i] = carry[i-1];
      end

      assign carry[i] = stg_in[i] && (cnt == TOP);

      always_ff @(posedge clk) begin
        if (!rst_n || clr)
          cnt <= '0;
        else if (stg_in[i])
          cnt <= carry[i] ? '0 : cnt + 1'b1;
      end
    end
  endgenerate

  assign range_strobe = range_lo ? carry[RANGE_STGS-1] : rise;

  always_comb begin
    case (dp_code)
      2'b00:   out_strobe = range_strobe;
      2'b01,
      2'b10:   out_strobe = carry[RANGE_STGS];
      default: out_strobe = carry[NSTG-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_out <= 1'b0;
    else
      div_out <= out_strobe & ~clr;
  end

endmodule

// File: rtl/range_decade_divider_chk.sv
module range_decade_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_in,
  input logic       range_lo,
  input logic [1:0] dp_code,
  input logic       div_out
);

  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R8
  rise_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> ($past(pulse_in, 2) && !$past(pulse_in, 3)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({range_lo, dp_code} != $past({range_lo, dp_code})) |=> !div_out);

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!range_lo && dp_code == 2'b00 && $stable({range_lo, dp_code})
     && $past(pulse_in, 1) && !$past(pulse_in, 2)) |=> div_out);

endmodule

bind range_decade_divider range_decade_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
  .range_lo(range_lo), .dp_code(dp_code), .div_out(div_out)
);

// File: tb/range_decade_divider_bench.sv
module range_decade_divider_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_in = 1'b0;
  logic       range_lo = 1'b0;
  logic [1:0] dp_code = 2'b00;
  logic       div_out;

  int checks = 0;
  int fails  = 0;
  int out_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  range_decade_divider u_range_decade_divider (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .range_lo(range_lo), .dp_code(dp_code), .div_out(div_out)
  );

  function automatic int ratio_of(input logic lo, input logic [1:0] code);
    int r;
    r = lo ? 1000 : 1;
    if (code == 2'b01 || code == 2'b10) r = r * 10;
    else if (code == 2'b11) r = r * 100;
    return r;
  endfunction

  // Behavioural reference model
  logic       m_p1 = 0, m_p2 = 0, exp_out = 0;
  logic [2:0] m_cfg = 3'b000;
  int         m_n = 0;

  always @(posedge clk) begin
    logic r;
    r = m_p1 & ~m_p2;
    m_p2 = m_p1;
    m_p1 = pulse_in;
    if (!rst_n) begin
      m_n = 0; exp_out = 0; m_p1 = 0; m_p2 = 0;
    end else if ({range_lo, dp_code} != m_cfg) begin
      m_n = 0; exp_out = 0;
    end else if (r) begin
      m_n++;
      exp_out = (m_n % ratio_of(range_lo, dp_code)) == 0;
    end else begin
      exp_out = 0;
    end
    m_cfg = {range_lo, dp_code};
  end

  // R6: cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (div_out !== exp_out) begin
        fails++;
        $display("FAIL R6 cycle compare: div_out=%0b expected %0b at %0t", div_out, exp_out, $time);
      end
      if (div_out === 1'b1) out_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      pulse_in = 1'b1;
      repeat (hi) @(negedge clk);
      pulse_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic lo, input logic [1:0] code);
    range_lo = lo;
    dp_code  = code;
    repeat (3) @(negedge clk);
    out_cnt = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset output", int'(div_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: pass-through at fastest rate
    set_cfg(1'b0, 2'b00);
    pulses(37, 1, 1);
    repeat (4) @(negedge clk);
    check("R2 divide by 1 count", out_cnt, 37);

    // R3: both mid codes divide by 10
    set_cfg(1'b0, 2'b01);
    pulses(95, 1, 1);
    repeat (4) @(negedge clk);
    check("R3 code 01 count", out_cnt, 9);
    set_cfg(1'b0, 2'b10);
    pulses(100, 2, 3);
    repeat (4) @(negedge clk);
    check("R3 code 10 count", out_cnt, 10);

    // R4: divide by 100
    set_cfg(1'b0, 2'b11);
    pulses(350, 1, 1);
    repeat (4) @(negedge clk);
    check("R4 code 11 count", out_cnt, 3);

    // R5: low range alone and in series with decimal divide
    set_cfg(1'b1, 2'b00);
    pulses(2500, 1, 1);
    repeat (4) @(negedge clk);
    check("R5 range divide 1000", out_cnt, 2);
    set_cfg(1'b1, 2'b01);
    pulses(10000, 1, 1);
    repeat (4) @(negedge clk);
    check("R5 range and decimal in series", out_cnt, 1);

    // R7: partial count discarded on control change
    set_cfg(1'b0, 2'b01);
    pulses(7, 1, 1);
    set_cfg(1'b0, 2'b10);
    pulses(9, 1, 1);
    repeat (4) @(negedge clk);
    check("R7 no pulse before full ratio", out_cnt, 0);
    pulses(1, 1, 1);
    repeat (4) @(negedge clk);
    check("R7 pulse after full ratio", out_cnt, 1);

    // R8: long high phases count once
    set_cfg(1'b0, 2'b00);
    pulses(5, 20, 2);
    repeat (4) @(negedge clk);
    check("R8 held input counted once", out_cnt, 5);

    // R1: reset clears partial counts
    set_cfg(1'b0, 2'b01);
    pulses(6, 1, 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    out_cnt = 0;
    pulses(9, 1, 1);
    repeat (4) @(negedge clk);
    check("R1 reset clears counters", out_cnt, 0);
    pulses(1, 1, 1);
    repeat (4) @(negedge clk);
    check("R1 first pulse after full ratio", out_cnt, 1);

    finish_run();
  end

endmodule